// File: doc/BRIEF.md
# Segment Display Image Update Controller

This block keeps the picture shown by a segment LCD controller. Software writes the picture into a set of working image words over a simple write-only register bus. The drive logic never reads those words. It reads a second copy, the display image, through a registered lookup port. The working image reaches the display image only when software asks for it, and then only at a frame boundary, so the panel never shows a half-written picture.

A frame-start pulse from the waveform sequencer marks each frame boundary. The pulse counts only while the controller is enabled. The block keeps a sticky frame-start flag and a sticky update-done flag. Software clears each flag by writing ones to a separate clear register. One registered interrupt line combines the two flags, each gated by its own enable bit. The block also reports a pending-request bit and a controller-on bit.

Register word addresses, with the default of eight image words: 0 to 7 hold the image words, 8 holds the interrupt enables, 9 is the request register and 10 is the clear register.

Top module: `seg_image_ctrl`

## Requirements
- R1: After a synchronous reset, all status outputs and `irq_o` are 0, and every display-image word reads back as zero.
- R2: A bus write to word address 0..7 changes only the working image. The display image keeps its old content until a later update takes place.
- R3: A bus write of 1 in bit 0 to word address 9 sets `stat_req_o` on the next clock edge. The bit then stays set until an accepted frame start copies the image.
- R4: When a frame start is accepted while a request is pending, all image words are copied into the display image on that clock edge. On the same edge `stat_req_o` clears and `stat_upd_o` sets.
- R5: A frame start is accepted only when `lcd_en_i` is high. Each accepted frame start sets `stat_sof_o` on the next edge. A frame start that arrives while `lcd_en_i` is low sets no flag and copies nothing.
- R6: A write to word address 10 clears `stat_sof_o` when bit 0 is 1 and clears `stat_upd_o` when bit 1 is 1. A 0 in a bit leaves its flag unchanged. A flag that is set and cleared in the same cycle ends up set.
- R7: Word address 8 holds two enables: bit 0 for frame start and bit 1 for update done. `irq_o` in each cycle is the OR of (frame-start flag AND bit 0) and (update-done flag AND bit 1), taken from the previous cycle.
- R8: While `stat_req_o` is set, writes to image words 0..7 are ignored.
- R9: `stat_on_o` follows `lcd_en_i` with one cycle of delay.
- R10: `disp_data_o` shows the display-image word selected by `disp_idx_i`, one cycle after the index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lcd_en_i | input | 1 | Controller enable |
| frame_start_i | input | 1 | One-cycle frame-boundary pulse from the sequencer |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | AW (4) | Register word address |
| bus_wdata_i | input | DW (32) | Register write data |
| disp_idx_i | input | IW (3) | Display-image word index for the drive logic |
| disp_data_o | output | DW (32) | Selected display-image word, registered |
| stat_on_o | output | 1 | Controller-on status |
| stat_req_o | output | 1 | Update request pending |
| stat_sof_o | output | 1 | Sticky frame-start flag |
| stat_upd_o | output | 1 | Sticky update-done flag |
| irq_o | output | 1 | Registered interrupt |

## Verification
The bench targets the cases an update controller is most likely to get wrong:
- **Early copy.** Writing the working image must leave the display image unchanged until a requested frame start arrives. A design that copies early would leak a half-built picture.
- **Unlocked writes.** A write during a pending request must have no effect. A design without the lock would show a value that was never meant to be displayed.
- **Set and clear in the same cycle.** A frame start and a clear-flag write in the same cycle must leave the flag set. A design that lets the clear win would lose a frame event.
- **Frame starts while disabled.** A frame start with the controller off must set no flag and copy nothing. A design that does not gate the pulse would set the flag or copy the image.
- **Interrupt masking and lag.** Each interrupt source is enabled and masked separately, and the one-cycle lag of the interrupt is checked at an exact cycle.

// File: rtl/seg_img_pkg.sv
`timescale 1ns/1ps
package seg_img_pkg;

  // Bit positions shared by the enable, request and clear registers
  localparam int BIT_SOF = 0;
  localparam int BIT_UPD = 1;
  localparam int BIT_REQ = 0;

  // Offsets of the control words past the last image word
  localparam int OFS_IEN = 0;
  localparam int OFS_REQ = 1;
  localparam int OFS_CLR = 2;

  typedef struct packed {
    logic upd;
    logic sof;
  } flag_t;

endpackage

// File: rtl/seg_img_regs.sv
`timescale 1ns/1ps
module seg_img_regs #(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  parameter int AW    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             wdata_i,
  input  logic                      lock_i,
  output logic [WORDS-1:0][DW-1:0]  img_o
);

  // One register per working-image word
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic hit;
    assign hit = we_i && !lock_i && (addr_i == AW'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        img_o[g] <= '0;
      end else if (hit) begin
        img_o[g] <= wdata_i;
      end
    end
  end

endmodule

// File: rtl/seg_img_shadow.sv
`timescale 1ns/1ps
module seg_img_shadow #(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  parameter int IW    = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_i,
  input  logic [WORDS-1:0][DW-1:0]  img_i,
  input  logic [IW-1:0]             rd_idx_i,
  output logic [DW-1:0]             rd_data_o
);

  logic [WORDS-1:0][DW-1:0] disp_q;

  // The display image is loaded from the working image as a whole
  always_ff @(posedge clk) begin
    if (rst) begin
      disp_q <= '0;
    end else if (load_i) begin
      disp_q <= img_i;
    end
  end

  // Registered lookup port for the drive logic
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else if (32'(rd_idx_i) < WORDS) begin
      rd_data_o <= disp_q[rd_idx_i];
    end else begin
      rd_data_o <= '0;
    end
  end

endmodule

// File: rtl/seg_img_status.sv
`timescale 1ns/1ps
module seg_img_status
  import seg_img_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic       sof_i,
  input  logic       ien_we_i,
  input  logic       req_we_i,
  input  logic       clr_we_i,
  input  logic [1:0] wbits_i,
  output logic       load_o,
  output logic       req_o,
  output flag_t      flags_o,
  output flag_t      ien_o,
  output logic       on_o,
  output logic       irq_o
);

  logic frame_ok;
  logic clr_sof;
  logic clr_upd;

  assign frame_ok = en_i && sof_i;
  assign load_o   = req_o && frame_ok;
  assign clr_sof  = clr_we_i && wbits_i[BIT_SOF];
  assign clr_upd  = clr_we_i && wbits_i[BIT_UPD];

  always_ff @(posedge clk) begin
    if (rst) begin
      on_o    <= 1'b0;
      ien_o   <= '0;
      req_o   <= 1'b0;
      flags_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      on_o <= en_i;
      if (ien_we_i) begin
        ien_o.sof <= wbits_i[BIT_SOF];
        ien_o.upd <= wbits_i[BIT_UPD];
      end
      req_o       <= (req_o && !frame_ok) || (req_we_i && wbits_i[BIT_REQ]);
      // A new event wins over a clear in the same cycle
      flags_o.sof <= frame_ok || (flags_o.sof && !clr_sof);
      flags_o.upd <= load_o   || (flags_o.upd && !clr_upd);
      irq_o       <= (flags_o.sof && ien_o.sof) || (flags_o.upd && ien_o.upd);
    end
  end

endmodule

// File: rtl/seg_image_ctrl.sv
`timescale 1ns/1ps
module seg_image_ctrl
  import seg_img_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  parameter int AW    = 4,
  localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lcd_en_i,
  input  logic          frame_start_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  input  logic [IW-1:0] disp_idx_i,
  output logic [DW-1:0] disp_data_o,
  output logic          stat_on_o,
  output logic          stat_req_o,
  output logic          stat_sof_o,
  output logic          stat_upd_o,
  output logic          irq_o
);

  localparam logic [AW-1:0] ADR_IEN = AW'(WORDS + OFS_IEN);
  localparam logic [AW-1:0] ADR_REQ = AW'(WORDS + OFS_REQ);
  localparam logic [AW-1:0] ADR_CLR = AW'(WORDS + OFS_CLR);

  logic [WORDS-1:0][DW-1:0] img_w;
  logic  load_w;
  logic  req_w;
  flag_t flags_w;
  flag_t ien_w;
  logic  ien_we;
  logic  req_we;
  logic  clr_we;

  assign ien_we = bus_we_i && (bus_addr_i == ADR_IEN);
  assign req_we = bus_we_i && (bus_addr_i == ADR_REQ);
  assign clr_we = bus_we_i && (bus_addr_i == ADR_CLR);

  seg_img_regs #(.WORDS(WORDS), .DW(DW), .AW(AW)) i_regs (
    .clk     (clk),
    .rst     (rst),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .lock_i  (req_w),
    .img_o   (img_w)
  );

  seg_img_shadow #(.WORDS(WORDS), .DW(DW), .IW(IW)) i_shadow (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load_w),
    .img_i     (img_w),
    .rd_idx_i  (disp_idx_i),
    .rd_data_o (disp_data_o)
  );

  seg_img_status i_status (
    .clk      (clk),
    .rst      (rst),
    .en_i     (lcd_en_i),
    .sof_i    (frame_start_i),
    .ien_we_i (ien_we),
    .req_we_i (req_we),
    .clr_we_i (clr_we),
    .wbits_i  (bus_wdata_i[1:0]),
    .load_o   (load_w),
    .req_o    (req_w),
    .flags_o  (flags_w),
    .ien_o    (ien_w),
    .on_o     (stat_on_o),
    .irq_o    (irq_o)
  );

  assign stat_req_o = req_w;
  assign stat_sof_o = flags_w.sof;
  assign stat_upd_o = flags_w.upd;

endmodule

// File: rtl/seg_img_chk.sv
`timescale 1ns/1ps
module seg_img_chk #(
  parameter int WORDS = 8,
  parameter int DW    = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     en,
  input logic                     sof,
  input logic                     req,
  input logic                     sof_f,
  input logic                     upd_f,
  input logic [1:0]               ien,
  input logic                     irq,
  input logic                     on,
  input logic [WORDS-1:0][DW-1:0] img
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req && !(sof && en)) |=> req);                                   // R3
  AST_COPY_DONE: assert property (@(posedge clk) disable iff (rst)
    (req && sof && en) |=> (!req || $past(req)) && upd_f);            // R4
  AST_SOF_SET: assert property (@(posedge clk) disable iff (rst)
    (sof && en) |=> sof_f);                                           // R5
  AST_SOF_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!sof_f && !(sof && en)) |=> !sof_f);                             // R5
  AST_IRQ_HIGH: assert property (@(posedge clk) disable iff (rst)
    $past((sof_f && ien[0]) || (upd_f && ien[1])) |-> irq);           // R7
  AST_IRQ_LOW: assert property (@(posedge clk) disable iff (rst)
    !$past((sof_f && ien[0]) || (upd_f && ien[1])) |-> !irq);         // R7
  AST_ON_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    on == $past(en));                                                 // R9
  AST_IMG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    req |=> $stable(img));                                            // R8

endmodule

bind seg_image_ctrl seg_img_chk #(.WORDS(WORDS), .DW(DW)) i_chk (
  .clk   (clk),
  .rst   (rst),
  .en    (lcd_en_i),
  .sof   (frame_start_i),
  .req   (req_w),
  .sof_f (flags_w.sof),
  .upd_f (flags_w.upd),
  .ien   ({ien_w.upd, ien_w.sof}),
  .irq   (irq_o),
  .on    (stat_on_o),
  .img   (img_w)
);

// File: tb/test_seg_image_ctrl.sv
`timescale 1ns/1ps
module test_seg_image_ctrl;

  localparam int WORDS = 8;
  localparam int DW    = 32;
  localparam int AW    = 4;
  localparam int IW    = 3;
  localparam logic [AW-1:0] A_IEN = 4'd8;
  localparam logic [AW-1:0] A_REQ = 4'd9;
  localparam logic [AW-1:0] A_CLR = 4'd10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lcd_en_i = 1'b0;
  logic          frame_start_i = 1'b0;
  logic          bus_we_i = 1'b0;
  logic [AW-1:0] bus_addr_i = '0;
  logic [DW-1:0] bus_wdata_i = '0;
  logic [IW-1:0] disp_idx_i = '0;
  logic [DW-1:0] disp_data_o;
  logic          stat_on_o, stat_req_o, stat_sof_o, stat_upd_o, irq_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  seg_image_ctrl #(.WORDS(WORDS), .DW(DW), .AW(AW)) i_seg_image_ctrl (
    .clk           (clk),
    .rst           (rst),
    .lcd_en_i      (lcd_en_i),
    .frame_start_i (frame_start_i),
    .bus_we_i      (bus_we_i),
    .bus_addr_i    (bus_addr_i),
    .bus_wdata_i   (bus_wdata_i),
    .disp_idx_i    (disp_idx_i),
    .disp_data_o   (disp_data_o),
    .stat_on_o     (stat_on_o),
    .stat_req_o    (stat_req_o),
    .stat_sof_o    (stat_sof_o),
    .stat_upd_o    (stat_upd_o),
    .irq_o         (irq_o)
  );

  function automatic logic [DW-1:0] pat(int i, logic [15:0] base);
    return {base, 16'(i * 16'h0101)};
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(logic [AW-1:0] a, logic [DW-1:0] d);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  task automatic frame();
    frame_start_i = 1'b1;
    @(negedge clk);
    frame_start_i = 1'b0;
  endtask

  task automatic rd(int idx, output logic [DW-1:0] v);
    disp_idx_i = IW'(idx);
    @(negedge clk);
    v = disp_data_o;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    chk("R1 sof flag", 32'(stat_sof_o), 0);
    chk("R1 upd flag", 32'(stat_upd_o), 0);
    chk("R1 req", 32'(stat_req_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 on", 32'(stat_on_o), 0);
    for (int i = 0; i < WORDS; i++) begin
      rd(i, v);
      chk("R1 R10 display zero", v, 0);
    end
  endtask

  task automatic t_enable();
    lcd_en_i = 1'b1;
    cyc(1);
    chk("R9 on follows enable", 32'(stat_on_o), 1);
  endtask

  task automatic t_load_no_req();
    logic [DW-1:0] v;
    for (int i = 0; i < WORDS; i++) bus_wr(AW'(i), pat(i, 16'hC0DE));
    rd(5, v);
    chk("R2 display unchanged after write", v, 0);
    frame();
    chk("R5 sof flag set", 32'(stat_sof_o), 1);
    chk("R5 upd flag clear", 32'(stat_upd_o), 0);
    rd(5, v);
    chk("R2 frame without request no copy", v, 0);
  endtask

  task automatic t_update();
    logic [DW-1:0] v;
    bus_wr(A_REQ, 32'h1);
    chk("R3 request set", 32'(stat_req_o), 1);
    cyc(5);
    chk("R3 request held", 32'(stat_req_o), 1);
    bus_wr(4'd2, 32'hDEAD_BEEF);
    bus_wr(A_CLR, 32'h1);
    frame();
    chk("R4 request cleared", 32'(stat_req_o), 0);
    chk("R4 upd flag set", 32'(stat_upd_o), 1);
    for (int i = 0; i < WORDS; i++) begin
      rd(i, v);
      chk("R4 display copied", v, pat(i, 16'hC0DE));
    end
    rd(2, v);
    chk("R8 locked write ignored", v, pat(2, 16'hC0DE));
  endtask

  task automatic t_clear();
    bus_wr(A_CLR, 32'h0);
    chk("R6 zero clear sof", 32'(stat_sof_o), 1);
    chk("R6 zero clear upd", 32'(stat_upd_o), 1);
    bus_wr(A_CLR, 32'h1);
    chk("R6 sof cleared", 32'(stat_sof_o), 0);
    chk("R6 upd kept", 32'(stat_upd_o), 1);
    bus_wr(A_CLR, 32'h2);
    chk("R6 upd cleared", 32'(stat_upd_o), 0);
    bus_we_i = 1'b1; bus_addr_i = A_CLR; bus_wdata_i = 32'h1;
    frame_start_i = 1'b1;
    @(negedge clk);
    bus_we_i = 1'b0; frame_start_i = 1'b0;
    chk("R6 set beats clear", 32'(stat_sof_o), 1);
    bus_wr(A_CLR, 32'h3);
    chk("R6 cleared again", 32'(stat_sof_o), 0);
  endtask

  task automatic t_irq();
    bus_wr(A_IEN, 32'h3);
    frame();
    chk("R7 irq lags flag", 32'(irq_o), 0);
    cyc(1);
    chk("R7 irq from sof", 32'(irq_o), 1);
    bus_wr(A_IEN, 32'h2);
    cyc(1);
    chk("R7 sof masked", 32'(irq_o), 0);
    bus_wr(A_REQ, 32'h1);
    frame();
    cyc(1);
    chk("R7 irq from upd", 32'(irq_o), 1);
    bus_wr(A_CLR, 32'h3);
    cyc(1);
    chk("R7 irq drops after clear", 32'(irq_o), 0);
    bus_wr(A_IEN, 32'h0);
    frame();
    cyc(1);
    chk("R7 all masked", 32'(irq_o), 0);
    bus_wr(A_CLR, 32'h3);
  endtask

  task automatic t_disabled();
    logic [DW-1:0] v;
    bus_wr(4'd0, 32'h1234_5678);
    lcd_en_i = 1'b0;
    cyc(1);
    chk("R9 on drops", 32'(stat_on_o), 0);
    bus_wr(A_REQ, 32'h1);
    frame();
    chk("R5 disabled no sof flag", 32'(stat_sof_o), 0);
    chk("R5 disabled request kept", 32'(stat_req_o), 1);
    rd(0, v);
    chk("R5 disabled no copy", v, pat(0, 16'hC0DE));
    lcd_en_i = 1'b1;
    frame();
    chk("R4 copy after enable", 32'(stat_upd_o), 1);
    rd(0, v);
    chk("R2 new word reaches display", v, 32'h1234_5678);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(1);
    t_reset();
    t_enable();
    t_load_no_req();
    t_update();
    t_clear();
    t_irq();
    t_disabled();
    cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule